// File: doc/BRIEF.md
# Branch Outcome Coverage Recorder

This block watches the fetch addresses of an external processor and records which way each conditional branch went. A host first loads an offset table that is indexed by address. An entry of zero marks an address as an ordinary instruction. A nonzero entry marks a branch and gives its signed displacement. Addresses arrive one per beat on a valid/ready sample stream. When the table reports a branch, the block derives two targets. The taken target is the branch address plus the sign-extended displacement. The not-taken limit is the branch address plus the prefetch depth. The block then watches the following addresses until one outcome is proven, and sets one bit in a two-half decision bitmap.

The lower half of the bitmap, indexed by the branch address, means "fell through". The upper half, indexed by the branch address plus the table depth, means "jumped". A host reads single bits through a request port that answers one cycle later. A clear command sweeps the bitmap back to zero one bit per cycle. During the sweep the block drops sample ready, so the sample stream is back-pressured. Any branch that was being tracked is abandoned.

Top module: `brc_recorder`

## Requirements
- R1: A table entry of zero marks a non-branch address; a sample whose entry is zero starts no tracking, so repeating that address sets no bitmap bit. The host writes the entry for address `tbl_wr_addr` in the cycle that `tbl_wr_en` is high.
- R2: A sample is accepted only in a cycle where `smp_valid` and `smp_ready` are both high. Samples offered with `smp_valid` low, or while `smp_ready` is low, have no effect on tracking or on the bitmap.
- R3: While a branch at address B with displacement D is tracked, an accepted sample equal to (B + sign-extended D) modulo 2^ADDR_W sets bitmap bit B + 2^ADDR_W (index MSB = 1) and ends tracking. Negative displacements and address wrap are included.
- R4: While a branch at B is tracked, an accepted sample A with (B + PREFETCH) < A < taken target, compared unsigned, sets bitmap bit B (index MSB = 0) and ends tracking. A sample equal to B + PREFETCH does not resolve the branch.
- R5: While tracking, samples that satisfy neither R3 nor R4 leave the branch tracked. This includes prefetch addresses and addresses that are themselves branches, and none of them starts a new branch.
- R6: The sample that resolves a branch is not examined as a new branch. The first accepted sample after it may start one.
- R7: Bitmap bits only get set by R3/R4; setting one bit leaves every other bit unchanged, and a set bit stays set until a clear.
- R8: `clr_req` while `busy` is low raises `busy` on the next cycle for exactly 2*2^ADDR_W cycles. The sweep zeroes every bitmap bit and abandons any tracked branch. `smp_ready` is low while `busy` is high. After reset `busy` is low.
- R9: `rd_req` with index `rd_idx` makes `rd_valid` high in the next cycle with `rd_bit` equal to that bitmap bit; `rd_valid` is low otherwise, including after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_wr_en | input | 1 | Offset table write strobe |
| tbl_wr_addr | input | ADDR_W | Offset table write address |
| tbl_wr_data | input | DISP_W | Signed displacement, zero = not a branch |
| smp_valid | input | 1 | Sample address valid |
| smp_ready | output | 1 | Block can accept a sample (low during clear sweep) |
| smp_addr | input | ADDR_W | Sampled fetch address |
| clr_req | input | 1 | Start bitmap clear sweep |
| busy | output | 1 | Clear sweep in progress |
| rd_req | input | 1 | Bitmap read request |
| rd_idx | input | ADDR_W+1 | Bitmap bit index, MSB selects taken half |
| rd_valid | output | 1 | Read data valid (one cycle after request) |
| rd_bit | output | 1 | Bitmap bit read |

## Verification
The hardest state to reach is a tracked branch that meets competing events. These include a clear arriving mid-track, samples offered while ready is low, and a resolving address that is itself a branch. The stimulus reaches them by loading branch entries whose targets land on other branch entries. It then starts a branch and fires the clear before the resolving address is sent, and keeps valid high during the sweep. A behavioural model that runs alongside compares busy, ready and every read response on each clock.

// File: rtl/brc_pkg.sv
package brc_pkg;
  typedef enum logic [0:0] {
    TRK_IDLE = 1'b0,
    TRK_WAIT = 1'b1
  } trk_state_e;
endpackage

// File: rtl/brc_offset_table.sv
module brc_offset_table #(
  parameter int ADDR_W = 8,
  parameter int DISP_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DISP_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DISP_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DISP_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/brc_tracker.sv
module brc_tracker
  import brc_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DISP_W   = 8,
  parameter int PREFETCH = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort,
  input  logic              in_vld,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DISP_W-1:0] disp,
  output logic              set_en,
  output logic [ADDR_W:0]   set_idx
);
  localparam logic [ADDR_W-1:0] PF_OFS = ADDR_W'(PREFETCH);

  trk_state_e        st, st_nxt;
  logic              s1_vld;
  logic [ADDR_W-1:0] s1_addr;
  logic [ADDR_W-1:0] br_q, tk_q, nt_q;
  logic [ADDR_W-1:0] ext;
  logic              is_branch, in_win, hit_tk, start;

  generate
    if (ADDR_W > DISP_W) begin : g_ext
      assign ext = {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp};
    end else begin : g_trunc
      assign ext = disp[ADDR_W-1:0];
    end
  endgenerate

  assign is_branch = (disp != '0);
  assign in_win    = (s1_addr > nt_q) && (s1_addr < tk_q);
  assign hit_tk    = (s1_addr == tk_q);
  assign start     = !abort && s1_vld && (st == TRK_IDLE) && is_branch;

  always_comb begin
    st_nxt  = st;
    set_en  = 1'b0;
    set_idx = '0;
    if (abort) begin
      st_nxt = TRK_IDLE;
    end else if (s1_vld) begin
      unique case (st)
        TRK_IDLE: if (is_branch) st_nxt = TRK_WAIT;
        TRK_WAIT: begin
          if (in_win) begin
            set_en  = 1'b1;
            set_idx = {1'b0, br_q};
            st_nxt  = TRK_IDLE;
          end else if (hit_tk) begin
            set_en  = 1'b1;
            set_idx = {1'b1, br_q};
            st_nxt  = TRK_IDLE;
          end
        end
        default: st_nxt = TRK_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= TRK_IDLE;
      s1_vld  <= 1'b0;
      s1_addr <= '0;
      br_q    <= '0;
      tk_q    <= '0;
      nt_q    <= '0;
    end else begin
      st      <= st_nxt;
      s1_vld  <= in_vld;
      s1_addr <= in_addr;
      if (start) begin
        br_q <= s1_addr;
        tk_q <= s1_addr + ext;
        nt_q <= s1_addr + PF_OFS;
      end
    end
  end
endmodule

// File: rtl/brc_decision_map.sv
module brc_decision_map #(
  parameter int IDX_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_start,
  output logic             busy,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_vld,
  output logic             rd_bit
);
  localparam int               BITS = 1 << IDX_W;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(BITS - 1);

  logic             mem [BITS];
  logic [IDX_W-1:0] cnt;
  logic             we, wbit;
  logic [IDX_W-1:0] widx;

  assign we   = busy || set_en;
  assign widx = busy ? cnt : set_idx;
  assign wbit = !busy;

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wbit;
    if (rd_en) rd_bit <= mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      rd_vld <= 1'b0;
    end else begin
      rd_vld <= rd_en;
      if (busy) begin
        if (cnt == LAST) busy <= 1'b0;
        cnt <= cnt + 1'b1;
      end else if (clr_start) begin
        busy <= 1'b1;
        cnt  <= '0;
      end
    end
  end
endmodule

// File: rtl/brc_recorder.sv
module brc_recorder #(
  parameter int ADDR_W   = 8,
  parameter int DISP_W   = 8,
  parameter int PREFETCH = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tbl_wr_en,
  input  logic [ADDR_W-1:0] tbl_wr_addr,
  input  logic [DISP_W-1:0] tbl_wr_data,
  input  logic              smp_valid,
  output logic              smp_ready,
  input  logic [ADDR_W-1:0] smp_addr,
  input  logic              clr_req,
  output logic              busy,
  input  logic              rd_req,
  input  logic [ADDR_W:0]   rd_idx,
  output logic              rd_valid,
  output logic              rd_bit
);
  localparam int IDX_W = ADDR_W + 1;

  logic              accept, abort, clr_start;
  logic [DISP_W-1:0] disp;
  logic              set_en;
  logic [IDX_W-1:0]  set_idx;

  assign smp_ready = !busy;
  assign accept    = smp_valid && smp_ready;
  assign abort     = clr_req || busy;
  assign clr_start = clr_req && !busy;

  brc_offset_table #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_tbl (
    .clk     (clk),
    .wr_en   (tbl_wr_en),
    .wr_addr (tbl_wr_addr),
    .wr_data (tbl_wr_data),
    .rd_en   (accept),
    .rd_addr (smp_addr),
    .rd_data (disp)
  );

  brc_tracker #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .PREFETCH(PREFETCH)) u_trk (
    .clk     (clk),
    .rst_n   (rst_n),
    .abort   (abort),
    .in_vld  (accept),
    .in_addr (smp_addr),
    .disp    (disp),
    .set_en  (set_en),
    .set_idx (set_idx)
  );

  brc_decision_map #(.IDX_W(IDX_W)) u_map (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_start (clr_start),
    .busy      (busy),
    .set_en    (set_en),
    .set_idx   (set_idx),
    .rd_en     (rd_req),
    .rd_idx    (rd_idx),
    .rd_vld    (rd_valid),
    .rd_bit    (rd_bit)
  );
endmodule

// File: rtl/brc_recorder_chk.sv
module brc_recorder_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic smp_valid,
  input logic smp_ready,
  input logic clr_req,
  input logic rd_req,
  input logic rd_valid,
  input logic set_en
);
  // R8: an accepted clear starts the sweep next cycle
  a_r8_clr_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !busy) |=> busy);

  // R8: the tracker never records while the sweep owns the bitmap
  a_r8_no_set_busy: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |-> !busy);

  // R2: every recorded outcome follows an accepted sample
  a_r2_set_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |-> $past(smp_valid && smp_ready));

  // R9: a read request is answered in the next cycle
  a_r9_rd_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);

  // R9: no response without a request
  a_r9_rd_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid);
endmodule

bind brc_recorder brc_recorder_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .smp_valid (smp_valid),
  .smp_ready (smp_ready),
  .clr_req   (clr_req),
  .rd_req    (rd_req),
  .rd_valid  (rd_valid),
  .set_en    (set_en)
);

// File: tb/brc_recorder_test.sv
`timescale 1ns/1ps
module brc_recorder_test;
  localparam int AW   = 8;
  localparam int DW   = 8;
  localparam int PF   = 5;
  localparam int SPAN = 1 << AW;
  localparam int MASK = SPAN - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tbl_wr_en = 1'b0;
  logic [AW-1:0] tbl_wr_addr = '0;
  logic [DW-1:0] tbl_wr_data = '0;
  logic          smp_valid = 1'b0;
  logic          smp_ready;
  logic [AW-1:0] smp_addr = '0;
  logic          clr_req = 1'b0;
  logic          busy;
  logic          rd_req = 1'b0;
  logic [AW:0]   rd_idx = '0;
  logic          rd_valid;
  logic          rd_bit;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  brc_recorder #(.ADDR_W(AW), .DISP_W(DW), .PREFETCH(PF)) uut (.*);

  // behavioural reference model
  bit m_map [2*SPAN];
  int m_tab [SPAN];
  bit m_busy, m_trk, m_pv, m_rv, m_rb, m_known;
  int m_cnt, m_br, m_tk, m_nt, m_pa, m_pd;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_cnt = 0; m_trk = 0; m_pv = 0; m_rv = 0;
    end else begin
      bit nrv, nrb, acc;
      int d;
      nrv = rd_req;
      nrb = m_map[rd_idx];
      if (clr_req || m_busy) m_trk = 0;
      else if (m_pv) begin
        if (!m_trk) begin
          if (m_pd != 0) begin
            d = (m_pd >= 128) ? m_pd - 256 : m_pd;
            m_trk = 1; m_br = m_pa;
            m_tk = (m_pa + d) & MASK;
            m_nt = (m_pa + PF) & MASK;
          end
        end else if (m_pa > m_nt && m_pa < m_tk) begin
          m_map[m_br] = 1; m_trk = 0;
        end else if (m_pa == m_tk) begin
          m_map[m_br + SPAN] = 1; m_trk = 0;
        end
      end
      acc = smp_valid && !m_busy;
      if (m_busy) begin
        m_map[m_cnt] = 0;
        if (m_cnt == 2*SPAN-1) begin m_busy = 0; m_known = 1; end
        m_cnt++;
      end else if (clr_req) begin
        m_busy = 1; m_cnt = 0;
      end
      if (acc) m_pd = m_tab[smp_addr];
      m_pv = acc; m_pa = smp_addr;
      if (tbl_wr_en) m_tab[tbl_wr_addr] = tbl_wr_data;
      m_rv = nrv; m_rb = nrb;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (busy !== m_busy || smp_ready !== !m_busy) begin
        fails++;
        $display("FAIL R8 busy/ready actual %b/%b expected %b/%b", busy, smp_ready, m_busy, !m_busy);
      end
      checks++;
      if (rd_valid !== m_rv || (m_rv && m_known && rd_bit !== m_rb)) begin
        fails++;
        $display("FAIL R9 read actual v=%b b=%b expected v=%b b=%b", rd_valid, rd_bit, m_rv, m_rb);
      end
    end
  end

  task automatic tbl_wr(input int a, input int v);
    @(negedge clk); tbl_wr_en = 1; tbl_wr_addr = AW'(a); tbl_wr_data = DW'(v);
    @(negedge clk); tbl_wr_en = 0;
  endtask

  task automatic smp(input int a);
    @(negedge clk); smp_valid = 1; smp_addr = AW'(a);
    @(posedge clk); #1 smp_valid = 0;
  endtask

  task automatic smp_inv(input int a);
    @(negedge clk); smp_valid = 0; smp_addr = AW'(a);
    @(posedge clk); #1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_chk(input int idx, input bit exp, input string tag);
    @(negedge clk); rd_req = 1; rd_idx = (AW+1)'(idx);
    @(negedge clk); rd_req = 0;
    checks++;
    if (rd_valid !== 1'b1 || rd_bit !== exp) begin
      fails++;
      $display("FAIL %s bit 0x%0h actual %b expected %b", tag, idx, rd_bit, exp);
    end
  endtask

  task automatic clear_and_time(input int hold_valid_cycles);
    int n;
    @(negedge clk); clr_req = 1;
    @(posedge clk); #1 clr_req = 0;
    n = 0;
    @(negedge clk);
    while (busy) begin
      n++;
      if (n <= hold_valid_cycles) begin smp_valid = 1; smp_addr = 8'h20; end
      else smp_valid = 0;
      @(negedge clk);
    end
    smp_valid = 0;
    checks++;
    if (n != 2*SPAN) begin
      fails++;
      $display("FAIL R8 busy cycles actual %0d expected %0d", n, 2*SPAN);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (busy !== 1'b0 || smp_ready !== 1'b1) begin
      fails++; $display("FAIL R8 reset busy/ready actual %b/%b expected 0/1", busy, smp_ready);
    end
    checks++;
    if (rd_valid !== 1'b0) begin
      fails++; $display("FAIL R9 reset rd_valid actual %b expected 0", rd_valid);
    end
    rst_n = 1;
    for (int i = 0; i < SPAN; i++) tbl_wr(i, 0);
    clear_and_time(0);
    tbl_wr(8'h20, 8'h12); tbl_wr(8'h40, 8'h30); tbl_wr(8'h60, 8'h10);
    tbl_wr(8'hF0, 8'h20); tbl_wr(8'h80, 8'hF0); tbl_wr(8'hA0, 8'h08);
    tbl_wr(8'hA8, 8'h04);
    idle(2);
    // R1: zero entry starts nothing
    smp(8'h33); smp(8'h33); idle(2);
    rd_chk(9'h133, 0, "R1 zero entry"); rd_chk(9'h033, 0, "R1 zero entry");
    // R5 prefetch window, then R3 taken
    smp(8'h20); for (int a = 8'h21; a <= 8'h25; a++) smp(a); idle(2);
    rd_chk(9'h120, 0, "R5 prefetch"); rd_chk(9'h020, 0, "R5 prefetch");
    smp(8'h32); idle(2);
    rd_chk(9'h120, 1, "R3 taken"); rd_chk(9'h020, 0, "R3 taken only");
    // R4 not-taken, boundary at limit
    smp(8'h40); smp(8'h41); smp(8'h45); idle(2);
    rd_chk(9'h040, 0, "R4 limit not resolving");
    smp(8'h46); idle(2);
    rd_chk(9'h040, 1, "R4 not taken"); rd_chk(9'h140, 0, "R4 not taken only");
    // R2 invalid samples ignored
    smp(8'h60); smp_inv(8'h70); smp_inv(8'h70); smp_inv(8'h70); idle(2);
    rd_chk(9'h160, 0, "R2 invalid ignored");
    smp(8'h70); idle(2);
    rd_chk(9'h160, 1, "R2 valid accepted");
    // R3 wrap
    smp(8'hF0); smp(8'h10); idle(2);
    rd_chk(9'h1F0, 1, "R3 wrap");
    // R3 negative, R5 branch during tracking ignored
    smp(8'h80); smp(8'h20); smp(8'h70); smp(8'h28); idle(2);
    rd_chk(9'h180, 1, "R3 negative disp");
    rd_chk(9'h020, 0, "R5 nested branch ignored");
    // R6 resolving sample is not a start
    smp(8'hA0); smp(8'hA8); smp(8'hAC); idle(2);
    rd_chk(9'h1A0, 1, "R6 resolve"); rd_chk(9'h1A8, 0, "R6 no start on resolver");
    smp(8'hA8); smp(8'hA9); smp(8'hAE); smp(8'hAC); idle(2);
    rd_chk(9'h1A8, 1, "R6 next start");
    // R7 sticky
    smp(8'h40); smp(8'h70); idle(2);
    rd_chk(9'h140, 1, "R7 set"); rd_chk(9'h040, 1, "R7 sticky");
    // R8 clear mid-track with samples offered during sweep
    smp(8'h20);
    clear_and_time(3);
    rd_chk(9'h040, 0, "R8 cleared"); rd_chk(9'h1A8, 0, "R8 cleared");
    smp(8'h32); idle(2);
    rd_chk(9'h120, 0, "R8 track abandoned");
    smp(8'h20); smp(8'h32); idle(2);
    rd_chk(9'h120, 1, "R6 restart after clear");
    idle(4);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    done = 1;
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule